// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, once per received frame, whether the frame should be kept. It compares the six destination-address bytes against a programmed 48-bit station address and the all-ones broadcast address. It also looks at the group (multicast) bit of the first byte. A 2-bit match mode selects which of these results count. The address bytes arrive one per cycle on a byte strobe, and idle cycles may fall between them. A start-of-frame strobe restarts the evaluation, so a frame that was cut short leaves nothing behind for the next one.

A receive path places the filter beside its byte deserialiser. It raises `frame_start` with, or before, the first destination byte. It then reads `frame_accept` in the cycle where `decision_valid` is high. Bytes after the sixth are payload and are ignored until the next start strobe. The interval from reset to the first start strobe is treated as if a start strobe had been seen.

Top module: `dest_addr_filter`

## Requirements
- R1: With `match_mode` = 2'b00 the receiver is off: every decision has `frame_accept` = 0.
- R2: With `match_mode` = 2'b01 every frame is accepted, whatever its destination.
- R3: With `match_mode` = 2'b10 or 2'b11, a frame is accepted when all six destination bytes equal the station address. The n-th received byte (n = 0..5) is compared with `station_addr[8n+7:8n]`. A mismatch in any single byte removes this reason to accept.
- R4: With `match_mode` = 2'b10 or 2'b11, a frame whose six destination bytes are all 8'hFF is accepted.
- R5: With `match_mode` = 2'b11, a frame is also accepted when bit 0 of its first destination byte is 1.
- R6: With `match_mode` = 2'b10, a frame that is neither station nor broadcast is rejected, even when bit 0 of its first byte is 1.
- R7: `decision_valid` is high for exactly one cycle: the cycle after the clock edge that takes the sixth byte. `frame_accept` can be high only in that cycle. The mode is sampled together with the sixth byte. Idle cycles between bytes do not change the result.
- R8: `frame_start` discards any partly evaluated frame. A byte presented in the same cycle as the strobe counts as byte 0. Match state from an earlier frame, including the multicast bit, never affects the next decision.
- R9: Bytes presented after the sixth and before the next `frame_start` produce no decision.
- R10: While reset is held and after it is released, `decision_valid` and `frame_accept` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame strobe; clears the running comparison |
| addr_byte_vld | input | 1 | A destination byte is present on `addr_byte` |
| addr_byte | input | 8 | Destination byte, first byte on the wire first |
| station_addr | input | 48 | Station address; bits [8n+7:8n] hold byte n |
| match_mode | input | 2 | 00 off, 01 all, 10 station+broadcast, 11 station+broadcast+multicast |
| decision_valid | output | 1 | One-cycle pulse when a decision is available |
| frame_accept | output | 1 | Accept result, qualified by `decision_valid` |

## Verification
The bench drives each byte just after a falling edge. The only result is due at the first rising edge after the sixth byte, since it passes through one register. The bench samples one time unit after that edge and expects `decision_valid` high. It samples one edge later and expects it low again. It also checks the edge after the fifth byte, where no decision may appear yet. After aborted frames and after trailing payload bytes, it checks every edge so that a stray decision pulse would be caught.

// File: rtl/daf_pkg.sv
package daf_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_ALL      = 2'b01,
    MODE_UNI_BC   = 2'b10,
    MODE_UNI_BC_MC = 2'b11
  } match_mode_e;

  typedef struct packed {
    logic station;
    logic bcast;
    logic mcast;
  } match_flags_t;

  localparam match_flags_t FLAGS_INIT = '{station: 1'b1, bcast: 1'b1, mcast: 1'b0};
endpackage

// File: rtl/dest_byte_tracker.sv
module dest_byte_tracker #(
  parameter int NUM_BYTES = 6,
  localparam int IDX_W = $clog2(NUM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             byte_vld,
  output logic [IDX_W-1:0] cur_idx,
  output logic             take,
  output logic             last
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    cur_idx = sof ? '0 : idx_q;
    take    = byte_vld && (cur_idx < IDX_W'(NUM_BYTES));
    last    = take && (cur_idx == IDX_W'(NUM_BYTES - 1));
    idx_d   = take ? cur_idx + 1'b1 : cur_idx;
    idx_en  = sof | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  // R9
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(NUM_BYTES));

  // R9
  idx_hold_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == IDX_W'(NUM_BYTES) && !sof) |=> idx_q == IDX_W'(NUM_BYTES));
endmodule

// File: rtl/dest_match_accum.sv
module dest_match_accum
  import daf_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int BYTE_W    = 8,
  localparam int IDX_W  = $clog2(NUM_BYTES + 1),
  localparam int ADDR_W = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              take,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] station_addr,
  output match_flags_t      flags_next
);
  logic [NUM_BYTES-1:0] lane_eq;
  logic                 sel_eq;
  match_flags_t         flags_q, flags_base;
  logic                 flags_en;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign lane_eq[g] = (byte_data == station_addr[g*BYTE_W +: BYTE_W]);
  end

  always_comb begin
    sel_eq = 1'b0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (cur_idx == IDX_W'(i)) sel_eq = lane_eq[i];
    end
  end

  always_comb begin
    flags_base = sof ? FLAGS_INIT : flags_q;
    flags_next = flags_base;
    if (take) begin
      flags_next.station = flags_base.station & sel_eq;
      flags_next.bcast   = flags_base.bcast & (&byte_data);
      if (cur_idx == '0) flags_next.mcast = byte_data[0];
    end
    flags_en = sof | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= FLAGS_INIT;
    else if (flags_en) flags_q <= flags_next;
  end

  // R8
  station_rise_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.station) |-> $past(sof));

  // R8
  bcast_rise_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.bcast) |-> $past(sof));
endmodule

// File: rtl/match_mode_decide.sv
module match_mode_decide
  import daf_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         last,
  input  match_mode_e  mode,
  input  match_flags_t flags,
  output logic         decision_valid,
  output logic         frame_accept
);
  logic acc_d;
  logic valid_q, acc_q;

  always_comb begin
    acc_d = 1'b0;
    if (mode == MODE_OFF)                       acc_d = 1'b0;
    else if (mode == MODE_ALL)                  acc_d = 1'b1;
    else if (flags.bcast)                       acc_d = 1'b1;
    else if (flags.station)                     acc_d = 1'b1;
    else if (mode == MODE_UNI_BC_MC && flags.mcast) acc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      valid_q <= last;
      acc_q   <= last & acc_d;
    end
  end

  assign decision_valid = valid_q;
  assign frame_accept   = acc_q;

  // R7
  accept_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |-> decision_valid);

  // R7
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |=> !decision_valid);

  // R1
  off_mode_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && mode == MODE_OFF) |=> !frame_accept);

  // R2
  all_mode_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && mode == MODE_ALL) |=> frame_accept);
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int BYTE_W    = 8,
  localparam int IDX_W  = $clog2(NUM_BYTES + 1),
  localparam int ADDR_W = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              addr_byte_vld,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic [ADDR_W-1:0] station_addr,
  input  logic [1:0]        match_mode,
  output logic              decision_valid,
  output logic              frame_accept
);
  logic [IDX_W-1:0] cur_idx;
  logic             take, last;
  match_flags_t     flags_next;

  dest_byte_tracker #(.NUM_BYTES(NUM_BYTES)) u_tracker (
    .clk      (clk),
    .rst_n    (rst_n),
    .sof      (frame_start),
    .byte_vld (addr_byte_vld),
    .cur_idx  (cur_idx),
    .take     (take),
    .last     (last)
  );

  dest_match_accum #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_accum (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (frame_start),
    .take         (take),
    .cur_idx      (cur_idx),
    .byte_data    (addr_byte),
    .station_addr (station_addr),
    .flags_next   (flags_next)
  );

  match_mode_decide u_decide (
    .clk            (clk),
    .rst_n          (rst_n),
    .last           (last),
    .mode           (match_mode_e'(match_mode)),
    .flags          (flags_next),
    .decision_valid (decision_valid),
    .frame_accept   (frame_accept)
  );

  // R9
  no_decision_without_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    decision_valid |-> $past(addr_byte_vld));
endmodule

// File: tb/tb_dest_addr_filter.sv
module tb_dest_addr_filter;
  logic        clk;
  logic        rst_n;
  logic        frame_start;
  logic        addr_byte_vld;
  logic [7:0]  addr_byte;
  logic [47:0] station_addr;
  logic [1:0]  match_mode;
  logic        decision_valid;
  logic        frame_accept;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [47:0] STA   = 48'hA4_3C_19_77_5E_02;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;

  dest_addr_filter dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_start    (frame_start),
    .addr_byte_vld  (addr_byte_vld),
    .addr_byte      (addr_byte),
    .station_addr   (station_addr),
    .match_mode     (match_mode),
    .decision_valid (decision_valid),
    .frame_accept   (frame_accept)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  function automatic logic expect_accept(input logic [47:0] d, input logic [1:0] m);
    logic st, bc, mc;
    st = (d == STA);
    bc = (d == BCAST);
    mc = d[0];
    case (m)
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return st | bc;
      default: return st | bc | mc;
    endcase
  endfunction

  function automatic string req_tag(input logic [47:0] d, input logic [1:0] m, input logic e);
    if (m == 2'b00) return "R1";
    if (m == 2'b01) return "R2";
    if (d == BCAST) return "R4";
    if (m == 2'b10 && !e) return "R6";
    if (m == 2'b11 && d[0] && d != STA) return "R5";
    return "R3";
  endfunction

  task automatic idle_cycle();
    @(negedge clk);
    frame_start   = 1'b0;
    addr_byte_vld = 1'b0;
  endtask

  task automatic send_frame(input logic [47:0] d, input logic [1:0] m, input int gap);
    logic e;
    string t;
    e = expect_accept(d, m);
    t = req_tag(d, m, e);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      frame_start   = (i == 0);
      addr_byte_vld = 1'b1;
      addr_byte     = d[8*i +: 8];
      match_mode    = m;
      if (i < 5) begin
        @(posedge clk); #1;
        if (i == 4) check("R7", "no decision before sixth byte", decision_valid, 1'b0);
        for (int g = 0; g < gap; g++) idle_cycle();
      end
    end
    @(posedge clk); #1;
    check("R7", "decision after sixth byte", decision_valid, 1'b1);
    check(t, $sformatf("accept d=%h mode=%0d", d, m), frame_accept, e);
    idle_cycle();
    @(posedge clk); #1;
    check("R7", "decision pulse ends", decision_valid, 1'b0);
  endtask

  task automatic partial_bytes(input logic [47:0] d, input int n, input logic with_start, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_start   = with_start && (i == 0);
      addr_byte_vld = 1'b1;
      addr_byte     = d[8*i +: 8];
      @(posedge clk); #1;
      check(tag, "no decision on partial or trailing bytes", decision_valid, 1'b0);
    end
    idle_cycle();
  endtask

  initial begin
    logic [47:0] pats [11];
    rst_n = 1'b0;
    frame_start = 1'b0;
    addr_byte_vld = 1'b0;
    addr_byte = 8'h00;
    station_addr = STA;
    match_mode = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check("R10", "valid in reset", decision_valid, 1'b0);
    check("R10", "accept in reset", frame_accept, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10", "valid after reset", decision_valid, 1'b0);
    check("R10", "accept after reset", frame_accept, 1'b0);

    pats[0]  = STA;
    pats[1]  = BCAST;
    pats[2]  = 48'h01_00_5E_00_00_33;
    pats[3]  = 48'h12_34_56_78_9A_BC;
    pats[4]  = STA ^ 48'h00_00_00_00_00_01;
    pats[5]  = BCAST ^ 48'h80_00_00_00_00_00;
    for (int k = 0; k < 5; k++) pats[6+k] = STA ^ (48'h10 << (8*k));
    // R3 R4 R5 R6 R1 R2: every mode against every pattern
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 11; p++)
        send_frame(pats[p], 2'(m), (m + p) % 3);

    // R3: last station byte differs
    send_frame(STA ^ (48'h10 << 40), 2'b10, 0);

    // R9: trailing bytes after a decision are ignored
    send_frame(STA, 2'b10, 0);
    partial_bytes(BCAST, 6, 1'b0, "R9");
    send_frame(BCAST, 2'b10, 1);

    // R8: aborted unicast frame, then a station frame restarts cleanly
    partial_bytes(pats[3], 3, 1'b1, "R8");
    send_frame(STA, 2'b10, 0);
    // R8: multicast first byte in an aborted frame does not leak
    match_mode = 2'b11;
    partial_bytes(pats[2], 4, 1'b1, "R8");
    send_frame(pats[3], 2'b11, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule